// File: doc/BRIEF.md
# Sequential Shift-Add Squaring Unit

This block squares an integer over several clock cycles. It has no hardware multiplier and uses only addition and shifts. A one-cycle start pulse presents an operand. That same value is loaded into two registers: the multiplicand, which shifts left on each step, and the multiplier, which shifts right on each step. On every step, if bit 0 of the multiplier is set, the multiplicand is added into an accumulator. The result is the low word of the product, so a negative operand gives the correct two's-complement low word of its square.

The unit stops as soon as no set bits remain in the multiplier. The run time therefore depends on the operand: it equals the bit length of the operand, and a full-width operand costs one load cycle plus one step per bit. A zero operand completes immediately after the load. While the unit is working it raises a busy flag. When it finishes it emits a one-cycle done pulse, and the result then holds until the next accepted start.

Top module: `seq_squarer`

## Requirements
- R1: While and after reset, with no start, busy, done and result are all 0.
- R2: For every accepted operand x, result equals the low WIDTH bits of x*x when done pulses. This includes operands with the top bit set, which are read as two's complement. Each operation starts from a cleared accumulator, so earlier operations have no influence.
- R3: An operand of 0 gives done on the first cycle after the start edge, with result 0, and busy never rises.
- R4: For a nonzero operand whose highest set bit is at index h, done is high exactly h+1 cycles after the start edge. Busy is high from the cycle after the start edge up to, but not including, the done cycle.
- R5: No operation takes more than WIDTH step cycles after its load cycle. An operand with bit WIDTH-1 set uses all of them.
- R6: A start pulse while busy is high is ignored. It produces no extra done pulse and does not change the result of the operation in flight.
- R7: Done lasts exactly one cycle, and busy is low while done is high.
- R8: After done, result stays unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; accepted only while not busy |
| operand | input | WIDTH | Value to be squared, sampled on an accepted start |
| busy | output | 1 | High while steps are running |
| done | output | 1 | One-cycle pulse when the result is final |
| result | output | WIDTH | Low WIDTH bits of operand squared |

## Verification
A corrupted shift or a wrong add decision shows up at the ports as a wrong result on the very done pulse of that operation. This is checked for sparse, dense, negative and full-width operands. A fault in the termination logic moves the done pulse away from the cycle predicted by the operand's bit length, or makes busy stay high or fall too early. The scoreboard catches this on the cycle concerned, because every expected item carries the cycle in which it is due. A start that leaks in while busy shows up as an unexpected second done pulse or as a changed result.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
   typedef enum logic [0:0] {
      SQ_IDLE = 1'b0,
      SQ_RUN  = 1'b1
   } sq_state_e;

   function automatic int unsigned sq_cnt_bits(input int unsigned w);
      return $clog2(w) + 1;
   endfunction
endpackage

// File: rtl/sqr_ctrl.sv
module sqr_ctrl
   import sqr_pkg::*;
#(
   parameter int unsigned WIDTH      = 32,
   parameter bit          EARLY_EXIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic op_zero,
   input  logic mplier_last,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);
   localparam int unsigned CNT_W = sq_cnt_bits(WIDTH);

   sq_state_e         state_q, state_d;
   logic [CNT_W-1:0]  cnt_q;
   logic              done_q;
   logic              finish;
   logic              zero_go;

   assign load = (state_q == SQ_IDLE) && start;
   assign step = (state_q == SQ_RUN);
   assign busy = step;
   assign done = done_q;

   generate
      if (EARLY_EXIT) begin : g_early
         assign finish  = mplier_last;
         assign zero_go = load && op_zero;
      end else begin : g_fixed
         assign finish  = (cnt_q == CNT_W'(WIDTH - 1));
         assign zero_go = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE: if (load && !zero_go) state_d = SQ_RUN;
         SQ_RUN:  if (finish)           state_d = SQ_IDLE;
         default:                       state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= zero_go || (step && finish);
         if (load)      cnt_q <= '0;
         else if (step) cnt_q <= cnt_q + 1'b1;
      end
   end

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy);
   p_busy_from_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(load));
   p_iter_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q < CNT_W'(WIDTH)));

   generate
      if (EARLY_EXIT) begin : g_zero_chk
         p_zero_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (load && op_zero) |=> (done_q && !busy));
      end
   endgenerate
endmodule

// File: rtl/sqr_dpath.sv
module sqr_dpath #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [WIDTH-1:0] operand,
   output logic             op_zero,
   output logic             mplier_last,
   output logic [WIDTH-1:0] acc
);
   logic [WIDTH-1:0] mcand_q;
   logic [WIDTH-1:0] mplier_q;
   logic [WIDTH-1:0] acc_q;
   logic [WIDTH-1:0] mplier_shr;
   logic [WIDTH-1:0] addend;

   assign op_zero     = (operand == '0);
   assign mplier_shr  = mplier_q >> 1;
   assign mplier_last = (mplier_shr == '0);
   assign addend      = mplier_q[0] ? mcand_q : '0;
   assign acc         = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         mplier_q <= '0;
         acc_q    <= '0;
      end else if (load) begin
         mcand_q  <= operand;
         mplier_q <= operand;
         acc_q    <= '0;
      end else if (step) begin
         mcand_q  <= mcand_q << 1;
         mplier_q <= mplier_shr;
         acc_q    <= acc_q + addend;
      end
   end

   p_mplier_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (mplier_q == ($past(mplier_q) >> 1)));
   p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ((acc_q == '0) && (mcand_q == mplier_q)));
   p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(acc_q));
endmodule

// File: rtl/seq_squarer.sv
module seq_squarer #(
   parameter int unsigned WIDTH      = 32,
   parameter bit          EARLY_EXIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] operand,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] result
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("seq_squarer: WIDTH must be at least 2");
      end
   endgenerate

   logic load;
   logic step;
   logic op_zero;
   logic mplier_last;

   sqr_ctrl #(.WIDTH(WIDTH), .EARLY_EXIT(EARLY_EXIT)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .op_zero    (op_zero),
      .mplier_last(mplier_last),
      .load       (load),
      .step       (step),
      .busy       (busy),
      .done       (done)
   );

   sqr_dpath #(.WIDTH(WIDTH)) u_dpath (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .step       (step),
      .operand    (operand),
      .op_zero    (op_zero),
      .mplier_last(mplier_last),
      .acc        (result)
   );

   p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result));
   p_done_has_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: tb/sim_seq_squarer.sv
module sim_seq_squarer;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] operand = '0;
   logic         busy, done;
   logic [W-1:0] result;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit finished = 1'b0;
   bit prev_done = 1'b0;

   typedef struct {
      logic [W-1:0] res;
      int           due;
      string        tag;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;   // 125 MHz

   always @(posedge clk) cyc <= cyc + 1;

   seq_squarer #(.WIDTH(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
      .busy(busy), .done(done), .result(result)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic int bitlen(input logic [W-1:0] x);
      for (int i = W - 1; i >= 0; i--) if (x[i]) return i + 1;
      return 0;
   endfunction

   function automatic logic [W-1:0] sq_low(input logic [W-1:0] x);
      logic [63:0] p;
      p = {32'b0, x} * {32'b0, x};
      return p[W-1:0];
   endfunction

   // monitor: pops expected items when done pulses
   always @(negedge clk) begin
      if (rst_n) begin
         if (done && prev_done) chk(1'b0, "R7 done longer than one cycle", 1, 0);
         if (done) begin
            chk(!busy, "R7 busy low during done", busy, 0);
            if (sb.size() == 0) begin
               chk(1'b0, "R6 unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(result == e.res, {e.tag, " result"}, result, e.res);
               chk(cyc == e.due, {e.tag, " done cycle (R4)"}, cyc, e.due);
            end
         end
         prev_done = done;
      end
   end

   task automatic run_op(input logic [W-1:0] x, input string tag);
      exp_t e;
      int   l;
      while (busy) @(negedge clk);
      l = bitlen(x);
      e.res = sq_low(x);
      e.due = cyc + 1 + l;
      e.tag = tag;
      sb.push_back(e);
      start = 1'b1;
      operand = x;
      @(negedge clk);
      start = 1'b0;
      if (x == '0) chk(!busy, "R3 busy stays low for zero", busy, 0);
      else         chk(busy, "R4 busy after start", busy, 1);
      while (sb.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(result == e.res, "R8 result held after done", result, e.res);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && result == '0, "R1 reset state", {busy, done, result}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && result == '0, "R1 idle after reset", {busy, done, result}, 0);

      run_op(32'd0, "R3 zero operand");
      run_op(32'd1, "R2 one");
      run_op(32'd3, "R2 three");
      run_op(32'd12345, "R2 mid value");
      run_op(32'h0000FFFF, "R2 dense low half");
      run_op(32'h80000000, "R5 top bit only");
      run_op(32'hFFFFFFFF, "R5 minus one");
      run_op(32'hFFFFFFFB, "R2 minus five");
      run_op(32'd0, "R3 zero after nonzero");
      run_op(32'h00010000, "R2 sparse");

      // start while busy must be ignored (R6)
      begin
         exp_t e;
         while (busy) @(negedge clk);
         e.res = sq_low(32'd7);
         e.due = cyc + 1 + 3;
         e.tag = "R6 in-flight op";
         sb.push_back(e);
         start = 1'b1; operand = 32'd7;
         @(negedge clk);
         operand = 32'd9;          // start still high while busy
         @(negedge clk);
         start = 1'b0; operand = 32'd0;
         repeat (12) @(negedge clk);
         chk(sb.size() == 0, "R6 in-flight op finished", sb.size(), 0);
         chk(result == 32'd49, "R6 result unaffected", result, 49);
      end

      for (int k = 0; k < 8; k++) run_op($urandom, "R2 random");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired (R4 completion)");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule